// File: doc/BRIEF.md
# SPI Transfer Length Command Encoder

This block sits in front of a generic command FIFO of a serial-flash controller. It takes one transfer request at a time and turns it into a string of fixed-format command entries. A request can be an opcode phase, a write run or a read run. It carries a byte count of up to 2^20, a flag that marks it as the last part of a transaction, and, for opcode phases, the opcode bytes themselves.

Long runs are split into power-of-two chunks. Each chunk is sent as an exponent entry whose immediate field holds the bit position. The split takes the set bits at position 8 and above, lowest first, and then sends one plain count entry for whatever is left. Opcode bytes go out one entry each. The block opens a transaction with a chip-select entry when the chip is not selected, and closes it with a release entry when the request is marked as last. Entries leave on a valid/ready handshake, and a one-cycle done pulse follows the final accepted entry.

Top module: `qspi_len_encoder`

## Requirements
- R1: After reset, cmdValid, done and errFlag are 0 and reqReady is 1. The chip counts as released, so the first request is preceded by a chip-select entry.
- R2: A write or read run whose remaining length is 1 to 255 ends with one entry. That entry has the exponent flag (bit 9) clear and the remaining count in bits 7:0.
- R3: While the remaining length exceeds 255, the block finds the lowest set bit p at position 8 or above. It emits an entry with bit 9 set and p in bits 7:0, then removes 2^p from the remaining length. When nothing remains after this step, no count entry follows.
- R4: Every run entry has bit 14 (lower bus), bit 12 (lower chip), bits 11:10 = 01 (single mode) and bit 8 (data transfer) set. It also has bit 16 set for a write or bit 17 set for a read. All other bits are 0.
- R5: In a read run, a non-exponent count that is not a multiple of 4 is rounded up to the next multiple of 4. A residual count of 253 to 255 becomes an exponent entry with p = 8.
- R6: An opcode request (reqOpcode with reqWrite) sends one entry per byte, with byte i taken from reqOpBytes[8i+7:8i]. Each entry carries the byte in bits 7:0 and bits 16, 14, 12 and 10. Bits 8 and 9 are clear.
- R7: If the chip is released when a valid request is accepted, the block first emits the select entry 0x05405 (bits 14, 12, 10 and immediate 5).
- R8: If reqEnd is set, the request's entries are followed by the release entry 0x04005 (bit 14 and immediate 5), and the chip counts as released again.
- R9: A request with a non-zero length and neither reqWrite nor reqRead is rejected. So is an opcode request longer than OP_MAX. A rejected request gives errFlag for one cycle, emits no entries and no done, and leaves the chip-select state unchanged.
- R10: While cmdValid is high and cmdReady is low, cmdData stays unchanged and cmdValid stays high.
- R11: done is high for exactly one cycle, the cycle after the last entry of the request is accepted. For a request that produces no entries, that is the cycle after the request is accepted.
- R12: A zero-length request emits only the select and release entries that the chip state and reqEnd call for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Encoder idle and able to take a request |
| reqWrite | input | 1 | Request direction: write |
| reqRead | input | 1 | Request direction: read (ignored if reqWrite is set) |
| reqOpcode | input | 1 | Request is an opcode phase (with reqWrite) |
| reqEnd | input | 1 | Release the chip after this request |
| reqLen | input | LEN_W | Byte count |
| reqOpBytes | input | OP_MAX*8 | Opcode bytes, byte 0 in the low bits |
| cmdValid | output | 1 | Command entry valid |
| cmdReady | input | 1 | Downstream FIFO accepts the entry |
| cmdData | output | 18 | Command entry |
| done | output | 1 | One-cycle pulse after the last entry |
| errFlag | output | 1 | One-cycle pulse for a rejected request |

## Verification
The bench uses the default LEN_W = 21 and OP_MAX = 4. With these values the full 2^20 byte count and the all-ones count 2^20-1 are both in reach. The all-ones count yields twelve exponent entries and a residual. The bench sweeps every write and read length from 0 to 300, which covers each rounding residue and the 253-255 read overflow next to the 255/256 boundary. It also runs sparse large counts and every opcode length up to the maximum. Back-pressure is applied on a fixed pattern to part of the requests.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int ENT_W   = 18;
  localparam int B_XFER  = 8;
  localparam int B_EXP   = 9;
  localparam int B_MODE  = 10;
  localparam int B_CSLO  = 12;
  localparam int B_BUSLO = 14;
  localparam int B_TX    = 16;
  localparam int B_RX    = 17;
  localparam logic [ENT_W-1:0] SEL_BASE =
    ENT_W'((1 << B_BUSLO) | (1 << B_CSLO) | (1 << B_MODE));
  localparam logic [ENT_W-1:0] CS_ON_ENT  = SEL_BASE | ENT_W'(5);
  localparam logic [ENT_W-1:0] CS_OFF_ENT = ENT_W'((1 << B_BUSLO) | 5);

  typedef struct packed {
    logic load;
    logic step;
    logic selOn;
    logic selOff;
  } ctrl_t;

  typedef enum logic [2:0] {S_IDLE, S_CSON, S_DATA, S_CSOFF, S_FIN} state_t;
endpackage

// File: rtl/qenc_datapath.sv
module qenc_datapath
  import qenc_pkg::*;
#(
  parameter int LEN_W  = 21,
  parameter int OP_MAX = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctrl,
  input  logic                reqWrite,
  input  logic                reqRead,
  input  logic                reqOpcode,
  input  logic [LEN_W-1:0]    reqLen,
  input  logic [OP_MAX*8-1:0] reqOpBytes,
  output logic [ENT_W-1:0]    cmdData,
  output logic                dataLast
);
  localparam int OPI_W = $clog2(OP_MAX + 1);

  logic [LEN_W-1:0]    remLen;
  logic [OPI_W-1:0]    opIdx;
  logic [OP_MAX*8-1:0] opBytes;
  logic                isRead, isOp;

  logic [LEN_W-1:0] cleared;
  logic [7:0]       expPos;
  logic             found;
  logic             isLong;
  logic [8:0]       rounded;
  logic [7:0]       curByte;
  logic [ENT_W-1:0] dataEnt;

  assign isLong  = remLen > LEN_W'(255);
  assign rounded = {1'b0, remLen[7:0]} + 9'd3;
  assign curByte = opBytes[opIdx*8 +: 8];

  always_comb begin
    cleared = remLen;
    expPos  = 8'd0;
    found   = 1'b0;
    for (int i = 8; i < LEN_W; i++) begin
      if (remLen[i] && !found) begin
        found      = 1'b1;
        expPos     = 8'(i);
        cleared[i] = 1'b0;
      end
    end
  end

  always_comb begin
    dataEnt  = SEL_BASE;
    dataLast = 1'b1;
    if (isOp) begin
      dataEnt[B_TX] = 1'b1;
      dataEnt[7:0]  = curByte;
      dataLast      = remLen == LEN_W'(1);
    end else begin
      dataEnt[B_XFER] = 1'b1;
      dataEnt[B_TX]   = !isRead;
      dataEnt[B_RX]   = isRead;
      if (isLong) begin
        dataEnt[B_EXP] = 1'b1;
        dataEnt[7:0]   = expPos;
        dataLast       = cleared == '0;
      end else if (isRead && remLen[7:0] > 8'd252) begin
        dataEnt[B_EXP] = 1'b1;
        dataEnt[7:0]   = 8'd8;
      end else if (isRead) begin
        dataEnt[7:0] = {rounded[7:2], 2'b00};
      end else begin
        dataEnt[7:0] = remLen[7:0];
      end
    end
  end

  assign cmdData = ctrl.selOn ? CS_ON_ENT : (ctrl.selOff ? CS_OFF_ENT : dataEnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remLen  <= '0;
      opIdx   <= '0;
      opBytes <= '0;
      isRead  <= 1'b0;
      isOp    <= 1'b0;
    end else if (ctrl.load) begin
      remLen  <= reqLen;
      opIdx   <= '0;
      opBytes <= reqOpBytes;
      isOp    <= reqOpcode && reqWrite;
      isRead  <= !reqWrite && reqRead;
    end else if (ctrl.step) begin
      if (isOp) begin
        remLen <= remLen - LEN_W'(1);
        opIdx  <= opIdx + OPI_W'(1);
      end else if (isLong) begin
        remLen <= cleared;
      end else begin
        remLen <= '0;
      end
    end
  end
endmodule

// File: rtl/qenc_control.sv
module qenc_control
  import qenc_pkg::*;
#(
  parameter int LEN_W  = 21,
  parameter int OP_MAX = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqRead,
  input  logic             reqOpcode,
  input  logic             reqEnd,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             dataLast,
  input  logic             cmdReady,
  output ctrl_t            ctrl,
  output logic             reqReady,
  output logic             cmdValid,
  output logic             done,
  output logic             errFlag
);
  state_t state, nextState;
  logic   csFree, endReg, hasData;
  logic   accept, badReq, lenNz;

  assign lenNz  = reqLen != '0;
  assign badReq = (lenNz && !reqWrite && !reqRead) ||
                  (reqOpcode && reqWrite && reqLen > LEN_W'(OP_MAX));

  assign reqReady = state == S_IDLE;
  assign accept   = reqValid && reqReady;
  assign cmdValid = (state == S_CSON) || (state == S_DATA) || (state == S_CSOFF);
  assign done     = state == S_FIN;

  assign ctrl.load   = accept && !badReq;
  assign ctrl.step   = (state == S_DATA) && cmdReady;
  assign ctrl.selOn  = state == S_CSON;
  assign ctrl.selOff = state == S_CSOFF;

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:
        if (ctrl.load) begin
          if (csFree)     nextState = S_CSON;
          else if (lenNz) nextState = S_DATA;
          else if (reqEnd) nextState = S_CSOFF;
          else            nextState = S_FIN;
        end
      S_CSON:
        if (cmdReady) begin
          if (hasData)     nextState = S_DATA;
          else if (endReg) nextState = S_CSOFF;
          else             nextState = S_FIN;
        end
      S_DATA:
        if (cmdReady && dataLast) nextState = endReg ? S_CSOFF : S_FIN;
      S_CSOFF:
        if (cmdReady) nextState = S_FIN;
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      csFree  <= 1'b1;
      endReg  <= 1'b0;
      hasData <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state   <= nextState;
      errFlag <= accept && badReq;
      if (ctrl.load) begin
        endReg  <= reqEnd;
        hasData <= lenNz;
      end
      if (state == S_CSON && cmdReady)  csFree <= 1'b0;
      if (state == S_CSOFF && cmdReady) csFree <= 1'b1;
    end
  end
endmodule

// File: rtl/qspi_len_encoder.sv
module qspi_len_encoder
  import qenc_pkg::*;
#(
  parameter int LEN_W  = 21,
  parameter int OP_MAX = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic                reqRead,
  input  logic                reqOpcode,
  input  logic                reqEnd,
  input  logic [LEN_W-1:0]    reqLen,
  input  logic [OP_MAX*8-1:0] reqOpBytes,
  output logic                cmdValid,
  input  logic                cmdReady,
  output logic [17:0]         cmdData,
  output logic                done,
  output logic                errFlag
);
  ctrl_t ctrl;
  logic  dataLast;

  qenc_control #(.LEN_W(LEN_W), .OP_MAX(OP_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRead(reqRead), .reqOpcode(reqOpcode), .reqEnd(reqEnd), .reqLen(reqLen),
    .dataLast(dataLast), .cmdReady(cmdReady), .ctrl(ctrl), .reqReady(reqReady),
    .cmdValid(cmdValid), .done(done), .errFlag(errFlag)
  );

  qenc_datapath #(.LEN_W(LEN_W), .OP_MAX(OP_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqWrite(reqWrite), .reqRead(reqRead),
    .reqOpcode(reqOpcode), .reqLen(reqLen), .reqOpBytes(reqOpBytes),
    .cmdData(cmdData), .dataLast(dataLast)
  );
endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
  parameter int LEN_W = 21
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        cmdValid,
  input logic        cmdReady,
  input logic [17:0] cmdData,
  input logic        done,
  input logic        errFlag
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdData));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !cmdValid && !done);

  p_idle_no_cmd_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !cmdValid);

  p_exp_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdData[9] |-> cmdData[7:0] >= 8'd8 && cmdData[7:0] < 8'(LEN_W));

  p_read_align_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdData[17] && !cmdData[9] |-> cmdData[1:0] == 2'b00);

  p_dir_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !(cmdData[16] && cmdData[17]));
endmodule

bind qspi_len_encoder qenc_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .cmdValid(cmdValid),
  .cmdReady(cmdReady), .cmdData(cmdData), .done(done), .errFlag(errFlag)
);

// File: tb/tb_qspi_len_encoder.sv
module tb_qspi_len_encoder;
  localparam int LEN_W  = 21;
  localparam int OP_MAX = 4;
  localparam logic [17:0] BASE  = 18'h05400;
  localparam logic [17:0] CSON  = 18'h05405;
  localparam logic [17:0] CSOFF = 18'h04005;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqRead = 1'b0, reqOpcode = 1'b0, reqEnd = 1'b0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [OP_MAX*8-1:0] reqOpBytes = '0;
  logic cmdReady = 1'b1;
  logic reqReady, cmdValid, done, errFlag;
  logic [17:0] cmdData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit csRel = 1'b1;

  always #2.5 clk = ~clk;

  qspi_len_encoder #(.LEN_W(LEN_W), .OP_MAX(OP_MAX)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRead(reqRead), .reqOpcode(reqOpcode), .reqEnd(reqEnd),
    .reqLen(reqLen), .reqOpBytes(reqOpBytes), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdData(cmdData), .done(done), .errFlag(errFlag)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic runReq(input bit w, input bit r, input bit op, input bit en,
                        input int len, input logic [31:0] bytes,
                        input string tag, input bit bp);
    logic [17:0] expQ[$];
    logic [17:0] gotQ[$];
    bit bad;
    int rem, n, lastAcc, p;
    bit held, doneSeen, errSeen, strayValid;
    logic [17:0] heldData, dirBits;
    bad = (len != 0 && !w && !r) || (op && w && len > OP_MAX);
    if (!bad) begin
      if (csRel) begin expQ.push_back(CSON); csRel = 1'b0; end
      rem = len;
      dirBits = w ? 18'h10000 : 18'h20000;
      for (int k = 0; rem > 0; k++) begin
        if (op && w) begin
          expQ.push_back(BASE | 18'h10000 | 18'(bytes[k*8 +: 8]));
          rem--;
        end else if (rem > 255) begin
          p = 8;
          while (((rem >> p) & 1) == 0) p++;
          expQ.push_back(BASE | dirBits | 18'h00300 | 18'(p));
          rem -= (1 << p);
        end else if (!w && rem > 252) begin
          expQ.push_back(BASE | dirBits | 18'h00300 | 18'd8);
          rem = 0;
        end else begin
          expQ.push_back(BASE | dirBits | 18'h00100 |
                         18'(w ? rem : ((rem + 3) / 4) * 4));
          rem = 0;
        end
      end
      if (en) begin expQ.push_back(CSOFF); csRel = 1'b1; end
    end
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqRead = r; reqOpcode = op; reqEnd = en;
    reqLen = LEN_W'(len); reqOpBytes = bytes;
    @(negedge clk);
    reqValid = 1'b0;
    n = 1; lastAcc = 0; held = 1'b0; doneSeen = 1'b0; errSeen = 1'b0; strayValid = 1'b0;
    while (n < 60) begin
      cmdReady = bp ? ((n % 3) != 1) : 1'b1;
      if (held) begin
        check(cmdValid && cmdData == heldData, "R10", "entry held under back-pressure",
              longint'(cmdData), longint'(heldData));
      end
      if (bad && cmdValid) strayValid = 1'b1;
      if (errFlag) errSeen = 1'b1;
      if (done) begin
        doneSeen = 1'b1;
        check(n == lastAcc + 1, "R11", "done cycle offset", n, lastAcc + 1);
        break;
      end
      held = cmdValid && !cmdReady;
      heldData = cmdData;
      if (cmdValid && cmdReady) begin
        gotQ.push_back(cmdData);
        lastAcc = n;
      end
      if (bad && n >= 3) break;
      @(negedge clk);
      n++;
    end
    cmdReady = 1'b1;
    if (bad) begin
      check(errSeen && !strayValid && !doneSeen, "R9", "rejected request quiet",
            longint'({errSeen, strayValid, doneSeen}), 64'h4);
    end else begin
      check(doneSeen, "R11", "done seen", longint'(doneSeen), 1);
      check(gotQ.size() == expQ.size(), tag, "entry count",
            gotQ.size(), expQ.size());
      for (int i = 0; i < gotQ.size() && i < expQ.size(); i++)
        check(gotQ[i] == expQ[i], tag, $sformatf("entry %0d len %0d", i, len),
              longint'(gotQ[i]), longint'(expQ[i]));
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!cmdValid && !done && !errFlag && reqReady, "R1", "reset outputs",
          longint'({cmdValid, done, errFlag, reqReady}), 64'h1);
    rstN = 1'b1;
    // R1/R7/R12: first request after reset, zero length, gets select only
    runReq(1'b1, 1'b0, 1'b0, 1'b0, 0, 32'h0, "R12", 1'b0);
    // R12: zero length with end, chip held: release only
    runReq(1'b1, 1'b0, 1'b0, 1'b1, 0, 32'h0, "R12", 1'b0);
    // R12: zero length, released and end: select and release
    runReq(1'b0, 1'b1, 1'b0, 1'b1, 0, 32'h0, "R8", 1'b0);
    // R2/R3/R4/R7/R8 write sweep
    for (int l = 0; l <= 300; l++)
      runReq(1'b1, 1'b0, 1'b0, (l % 2) == 1, l, 32'h0, l > 255 ? "R3" : "R2", (l % 3) == 0);
    // R5 read sweep covering rounding and 253..255
    for (int l = 0; l <= 300; l++)
      runReq(1'b0, 1'b1, 1'b0, (l % 4) == 0, l, 32'h0, "R5", (l % 5) == 0);
    // R3 large counts
    runReq(1'b1, 1'b0, 1'b0, 1'b0, 1 << 20, 32'h0, "R3", 1'b0);
    runReq(1'b0, 1'b1, 1'b0, 1'b1, (1 << 20) - 1, 32'h0, "R3", 1'b1);
    runReq(1'b1, 1'b0, 1'b0, 1'b1, (1 << 20) - 1, 32'h0, "R3", 1'b0);
    runReq(1'b0, 1'b1, 1'b0, 1'b0, 1024 + 512 + 7, 32'h0, "R3", 1'b0);
    runReq(1'b1, 1'b1, 1'b0, 1'b1, 4096 + 255, 32'h0, "R4", 1'b1);
    // R6 opcode phases
    for (int l = 0; l <= OP_MAX; l++)
      runReq(1'b1, 1'b0, 1'b1, 1'b0, l, 32'hA5_3C_9F_06 ^ l, "R6", (l % 2) == 0);
    runReq(1'b1, 1'b0, 1'b1, 1'b1, 2, 32'h0000_FF00, "R6", 1'b1);
    // R9 rejections, then a request proving chip state unchanged
    runReq(1'b0, 1'b0, 1'b0, 1'b1, 5, 32'h0, "R9", 1'b0);
    runReq(1'b1, 1'b0, 1'b1, 1'b1, OP_MAX + 1, 32'h0, "R9", 1'b0);
    runReq(1'b1, 1'b0, 1'b0, 1'b0, 3, 32'h0, "R7", 1'b0);
    runReq(1'b0, 1'b0, 1'b0, 1'b0, 9, 32'h0, "R9", 1'b0);
    runReq(1'b0, 1'b1, 1'b0, 1'b1, 6, 32'h0, "R8", 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule